// File: doc/BRIEF.md
# Mailbox and Stream Bus-Cycle Scheduler

This block chooses the next byte-wide cycle on a shared peripheral bus. There are two sources of work. The first is a host mailbox register that describes one read or one write to a chosen guest device and register. The second is a stream of 32-bit words taken from a code FIFO. Each word is split into bytes, and each byte is written to one guest and register that the host selects. Each cycle is handed to a separate cycle-timing engine as a one-clock start pulse with a request (guest, register, write flag, data byte). The engine later returns a done pulse with a time-out qualifier and, for reads, a data byte.

The scheduler starts at most one cycle at a time. A pending mailbox request always wins the next free cycle slot, but it never cuts a stream cycle short. A stream cycle that times out sets a time-out flag of its own, separate from the mailbox time-out flag. Both flags stay set until the host clears them.

Top module: `bus_cycle_sched`

## Requirements
- R1: After reset the pending bit, both time-out flags, `cyc_start` and `fifo_pop` are all 0.
- R2: A stream cycle is started only when `fifo_empty` is 0, the pending bit is 0 and `guest_ready` is 1. If `guest_ready` is low, no stream cycle starts.
- R3: A stream cycle writes (`cyc_write`=1) to `strm_guest`/`strm_reg`. The bytes of a word go out least significant first: bits 7:0, then 15:8, 23:16 and 31:24.
- R4: `fifo_pop` pulses exactly once per word, together with the done of the word's fourth byte. A byte whose cycle timed out still counts as sent.
- R5: If the pending bit is set while a stream cycle runs, that cycle completes, and the mailbox cycle is the next one started, even though the FIFO still holds data.
- R6: A mailbox cycle with direction 1 is a write. It carries the mailbox data byte, guest index and register index.
- R7: A mailbox cycle with direction 0 is a read. On a done without time-out, the returned byte is stored into the mailbox data field.
- R8: The pending bit returns to 0 when the mailbox cycle is done.
- R9: A mailbox cycle that times out sets the mailbox time-out flag and clears the pending bit. The data field is left unchanged.
- R10: A stream cycle that times out sets the stream time-out flag and leaves the mailbox time-out flag alone.
- R11: Both time-out flags are sticky and are cleared by a 1 on their clear input. If a set and a clear fall in the same cycle, the set wins.
- R12: A host mailbox write (`host_wr`) is ignored entirely while the pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe to the mailbox register |
| host_go | input | 1 | Value written to the pending bit |
| host_dir | input | 1 | Value written to the direction bit (1 write, 0 read) |
| host_guest | input | GUEST_W | Value written to the guest index |
| host_reg | input | REG_W | Value written to the register index |
| host_data | input | DATA_W | Value written to the data field |
| host_clr_mto | input | 1 | Clears the mailbox time-out flag when 1 |
| host_clr_sto | input | 1 | Clears the stream time-out flag when 1 |
| strm_guest | input | GUEST_W | Guest targeted by stream bytes |
| strm_reg | input | REG_W | Register targeted by stream bytes |
| mbox_pend | output | 1 | Mailbox pending bit |
| mbox_dir | output | 1 | Mailbox direction bit |
| mbox_guest | output | GUEST_W | Mailbox guest index |
| mbox_reg | output | REG_W | Mailbox register index |
| mbox_data | output | DATA_W | Mailbox data field |
| mbox_timeout | output | 1 | Sticky mailbox time-out flag |
| strm_timeout | output | 1 | Sticky stream time-out flag |
| fifo_empty | input | 1 | Code FIFO is empty |
| fifo_word | input | WORD_W | Head word of the FIFO (first-word fall-through) |
| fifo_pop | output | 1 | Removes the head word |
| guest_ready | input | 1 | Stream guest can accept a byte |
| cyc_start | output | 1 | One-clock start pulse to the timing engine |
| cyc_guest | output | GUEST_W | Guest of the current cycle |
| cyc_reg | output | REG_W | Register of the current cycle |
| cyc_write | output | 1 | 1 for a write cycle, 0 for a read |
| cyc_data | output | DATA_W | Byte to write |
| cyc_done | input | 1 | Engine finished the cycle |
| cyc_timeout | input | 1 | Qualifies `cyc_done`: the cycle was aborted |
| cyc_rdata | input | DATA_W | Byte read, valid with `cyc_done` |

## Verification
Two cases land in the same clock. First, the engine reports a timed-out cycle in the very cycle the host pulses the matching clear input. The bench provokes this by polling for `cyc_done` on the falling edge and raising the clear right then; the flag must read 1 afterwards. Second, the host raises the pending bit while a stream byte is still on the bus. The bench judges this by the order of the logged requests: the first byte, then the mailbox cycle, then the remaining three bytes.

// File: rtl/sched_pkg.sv
package sched_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_MBOX = 2'd1,
      ARB_STRM = 2'd2
   } arb_state_t;
endpackage

// File: rtl/mbox_reg.sv
module mbox_reg #(
   parameter int GUEST_W = 3,
   parameter int REG_W   = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_go,
   input  logic               host_dir,
   input  logic [GUEST_W-1:0] host_guest,
   input  logic [REG_W-1:0]   host_reg,
   input  logic [DATA_W-1:0]  host_data,
   input  logic               clr_mto,
   input  logic               clr_sto,
   input  logic               done_mb,
   input  logic               done_st,
   input  logic               rsp_timeout,
   input  logic [DATA_W-1:0]  rsp_rdata,
   output logic               pend,
   output logic               dir,
   output logic [GUEST_W-1:0] guest,
   output logic [REG_W-1:0]   regi,
   output logic [DATA_W-1:0]  data,
   output logic               mto,
   output logic               sto
);
   logic accept_wr;
   logic mb_fail;
   logic st_fail;

   assign accept_wr = host_wr && !pend;
   assign mb_fail   = done_mb && rsp_timeout;
   assign st_fail   = done_st && rsp_timeout;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         dir   <= 1'b0;
         guest <= '0;
         regi  <= '0;
         data  <= '0;
      end else if (accept_wr) begin
         pend  <= host_go;
         dir   <= host_dir;
         guest <= host_guest;
         regi  <= host_reg;
         data  <= host_data;
      end else if (done_mb) begin
         pend <= 1'b0;
         if (!rsp_timeout && !dir) begin
            data <= rsp_rdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mto <= 1'b0;
         sto <= 1'b0;
      end else begin
         if (mb_fail)      mto <= 1'b1;
         else if (clr_mto) mto <= 1'b0;
         if (st_fail)      sto <= 1'b1;
         else if (clr_sto) sto <= 1'b0;
      end
   end

   // R8: a completed mailbox cycle leaves the pending bit clear
   a_r8_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
      done_mb |=> !pend);
   // R11: flags hold unless cleared
   a_r11_mto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mto && !clr_mto) |=> mto);
   a_r11_sto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sto && !clr_sto) |=> sto);
   // R12: fields frozen while pending and no completion
   a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !done_mb) |=> ($stable(data) && $stable(guest) && $stable(regi) && $stable(dir)));
endmodule

// File: rtl/stream_unpack.sv
module stream_unpack #(
   parameter int WORD_W = 32,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_in,
   input  logic              adv,
   output logic [DATA_W-1:0] byte_out,
   output logic              pop
);
   localparam int LANES = WORD_W / DATA_W;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

   logic [DATA_W-1:0] lane [LANES];
   logic [IDX_W-1:0]  idx;
   logic              at_last;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word_in[g*DATA_W +: DATA_W];
   end

   assign byte_out = lane[idx];
   assign at_last  = (idx == LAST);
   assign pop      = adv && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (adv) begin
         idx <= at_last ? '0 : idx + 1'b1;
      end
   end

   // R4: the lane index never leaves the word
   a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST);
   // R4: index wraps to lane zero after a pop
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (idx == '0));
endmodule

// File: rtl/cycle_arbiter.sv
module cycle_arbiter
   import sched_pkg::*;
#(
   parameter int GUEST_W = 3,
   parameter int REG_W   = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mb_pend,
   input  logic               mb_dir,
   input  logic [GUEST_W-1:0] mb_guest,
   input  logic [REG_W-1:0]   mb_reg,
   input  logic [DATA_W-1:0]  mb_data,
   input  logic [GUEST_W-1:0] st_guest,
   input  logic [REG_W-1:0]   st_reg,
   input  logic [DATA_W-1:0]  st_byte,
   input  logic               fifo_empty,
   input  logic               guest_ready,
   input  logic               rsp_done,
   output logic               req_start,
   output logic [GUEST_W-1:0] req_guest,
   output logic [REG_W-1:0]   req_reg,
   output logic               req_write,
   output logic [DATA_W-1:0]  req_data,
   output logic               done_mb,
   output logic               done_st
);
   arb_state_t state;
   logic       go_mb;
   logic       go_st;

   assign go_mb   = (state == ARB_IDLE) && mb_pend;
   assign go_st   = (state == ARB_IDLE) && !mb_pend && !fifo_empty && guest_ready;
   assign done_mb = rsp_done && (state == ARB_MBOX);
   assign done_st = rsp_done && (state == ARB_STRM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ARB_IDLE;
         req_start <= 1'b0;
         req_guest <= '0;
         req_reg   <= '0;
         req_write <= 1'b0;
         req_data  <= '0;
      end else begin
         req_start <= 1'b0;
         unique case (state)
            ARB_IDLE: begin
               if (go_mb) begin
                  state     <= ARB_MBOX;
                  req_start <= 1'b1;
                  req_guest <= mb_guest;
                  req_reg   <= mb_reg;
                  req_write <= mb_dir;
                  req_data  <= mb_data;
               end else if (go_st) begin
                  state     <= ARB_STRM;
                  req_start <= 1'b1;
                  req_guest <= st_guest;
                  req_reg   <= st_reg;
                  req_write <= 1'b1;
                  req_data  <= st_byte;
               end
            end
            ARB_MBOX, ARB_STRM: begin
               if (rsp_done) state <= ARB_IDLE;
            end
            default: state <= ARB_IDLE;
         endcase
      end
   end

   // R2: a stream start follows a cycle with all three conditions true
   a_r2_stream_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && state == ARB_STRM) |-> ($past(!mb_pend) && $past(!fifo_empty) && $past(guest_ready)));
   // R5: pending at the end of a stream cycle makes the mailbox go next
   a_r5_mbox_next: assert property (@(posedge clk) disable iff (!rst_n)
      (done_st && mb_pend) |-> ##2 (req_start && state == ARB_MBOX));
   // R5: start pulses are single cycles
   a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      req_start |=> !req_start);
endmodule

// File: rtl/bus_cycle_sched.sv
module bus_cycle_sched #(
   parameter int GUEST_W = 3,
   parameter int REG_W   = 3,
   parameter int DATA_W  = 8,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_go,
   input  logic               host_dir,
   input  logic [GUEST_W-1:0] host_guest,
   input  logic [REG_W-1:0]   host_reg,
   input  logic [DATA_W-1:0]  host_data,
   input  logic               host_clr_mto,
   input  logic               host_clr_sto,
   input  logic [GUEST_W-1:0] strm_guest,
   input  logic [REG_W-1:0]   strm_reg,
   output logic               mbox_pend,
   output logic               mbox_dir,
   output logic [GUEST_W-1:0] mbox_guest,
   output logic [REG_W-1:0]   mbox_reg,
   output logic [DATA_W-1:0]  mbox_data,
   output logic               mbox_timeout,
   output logic               strm_timeout,
   input  logic               fifo_empty,
   input  logic [WORD_W-1:0]  fifo_word,
   output logic               fifo_pop,
   input  logic               guest_ready,
   output logic               cyc_start,
   output logic [GUEST_W-1:0] cyc_guest,
   output logic [REG_W-1:0]   cyc_reg,
   output logic               cyc_write,
   output logic [DATA_W-1:0]  cyc_data,
   input  logic               cyc_done,
   input  logic               cyc_timeout,
   input  logic [DATA_W-1:0]  cyc_rdata
);
   localparam int LANES = WORD_W / DATA_W;

   if (WORD_W % DATA_W != 0) begin : g_bad_ratio
      $error("WORD_W must be a multiple of DATA_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("a word must hold at least two bytes");
   end
   if (GUEST_W < 1 || REG_W < 1) begin : g_bad_addr
      $error("address fields need at least one bit");
   end

   logic              done_mb;
   logic              done_st;
   logic [DATA_W-1:0] st_byte;

   mbox_reg #(.GUEST_W(GUEST_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_go    (host_go),
      .host_dir   (host_dir),
      .host_guest (host_guest),
      .host_reg   (host_reg),
      .host_data  (host_data),
      .clr_mto    (host_clr_mto),
      .clr_sto    (host_clr_sto),
      .done_mb    (done_mb),
      .done_st    (done_st),
      .rsp_timeout(cyc_timeout),
      .rsp_rdata  (cyc_rdata),
      .pend       (mbox_pend),
      .dir        (mbox_dir),
      .guest      (mbox_guest),
      .regi       (mbox_reg),
      .data       (mbox_data),
      .mto        (mbox_timeout),
      .sto        (strm_timeout)
   );

   stream_unpack #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_in (fifo_word),
      .adv     (done_st),
      .byte_out(st_byte),
      .pop     (fifo_pop)
   );

   cycle_arbiter #(.GUEST_W(GUEST_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .mb_pend    (mbox_pend),
      .mb_dir     (mbox_dir),
      .mb_guest   (mbox_guest),
      .mb_reg     (mbox_reg),
      .mb_data    (mbox_data),
      .st_guest   (strm_guest),
      .st_reg     (strm_reg),
      .st_byte    (st_byte),
      .fifo_empty (fifo_empty),
      .guest_ready(guest_ready),
      .rsp_done   (cyc_done),
      .req_start  (cyc_start),
      .req_guest  (cyc_guest),
      .req_reg    (cyc_reg),
      .req_write  (cyc_write),
      .req_data   (cyc_data),
      .done_mb    (done_mb),
      .done_st    (done_st)
   );

   // R4: the head word is only removed when one is present
   a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);
   // R1: nothing is requested in the first cycle after reset
   a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cyc_start);
endmodule

// File: tb/bus_cycle_sched_bench.sv
module bus_cycle_sched_bench;
   localparam int GW = 3, RW = 3, DW = 8, WW = 32;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          host_wr = 0, host_go = 0, host_dir = 0;
   logic [GW-1:0] host_guest = '0;
   logic [RW-1:0] host_reg = '0;
   logic [DW-1:0] host_data = '0;
   logic          host_clr_mto = 0, host_clr_sto = 0;
   logic [GW-1:0] strm_guest = 3'd6;
   logic [RW-1:0] strm_reg = 3'd4;
   logic          mbox_pend, mbox_dir, mbox_timeout, strm_timeout;
   logic [GW-1:0] mbox_guest;
   logic [RW-1:0] mbox_reg;
   logic [DW-1:0] mbox_data;
   logic          fifo_empty, fifo_pop;
   logic [WW-1:0] fifo_word;
   logic          guest_ready = 0;
   logic          cyc_start, cyc_write;
   logic [GW-1:0] cyc_guest;
   logic [RW-1:0] cyc_reg;
   logic [DW-1:0] cyc_data;
   logic          cyc_done = 0, cyc_timeout = 0;
   logic [DW-1:0] cyc_rdata = '0;

   bus_cycle_sched u_bus_cycle_sched (.*);

   // FIFO model
   logic [WW-1:0] fmem [8];
   logic [2:0]    wp = '0, rp = '0;
   int            pops = 0;
   assign fifo_empty = (wp == rp);
   assign fifo_word  = fmem[rp];
   always @(posedge clk) if (fifo_pop) begin rp <= rp + 1'b1; pops <= pops + 1; end

   // engine model and request log
   logic          tb_to = 0;
   logic [DW-1:0] tb_rd = '0;
   int            cnt = 0;
   int            nlog = 0;
   logic [GW-1:0] lg_guest [64];
   logic [RW-1:0] lg_reg [64];
   logic          lg_wr [64];
   logic [DW-1:0] lg_data [64];
   always @(posedge clk) begin
      cyc_done <= 1'b0;
      if (cyc_start) begin
         lg_guest[nlog] <= cyc_guest; lg_reg[nlog] <= cyc_reg;
         lg_wr[nlog] <= cyc_write;    lg_data[nlog] <= cyc_data;
         nlog <= nlog + 1;
         cnt <= LAT;
      end else if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) begin
            cyc_done    <= 1'b1;
            cyc_timeout <= tb_to;
            cyc_rdata   <= tb_rd;
         end
      end
   end

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [WW-1:0] w);
      @(negedge clk);
      fmem[wp] = w;
      wp = wp + 1'b1;
   endtask

   task automatic mbox_write(input bit go, input bit d, input int g, input int r, input int v);
      @(negedge clk);
      host_wr = 1; host_go = go; host_dir = d;
      host_guest = GW'(g); host_reg = RW'(r); host_data = DW'(v);
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic chk_stream(input int base, input logic [WW-1:0] w, input string tag);
      for (int i = 0; i < 4; i++) begin
         chk(lg_data[base+i] == w[i*8 +: 8] && lg_wr[base+i] && lg_guest[base+i] == strm_guest
             && lg_reg[base+i] == strm_reg, tag, lg_data[base+i], w[i*8 +: 8]);
      end
   endtask

   task automatic t_reset();
      chk(!mbox_pend && !mbox_timeout && !strm_timeout, "R1 flags", {mbox_pend, mbox_timeout, strm_timeout}, 0);
      chk(!cyc_start && !fifo_pop, "R1 outputs", {cyc_start, fifo_pop}, 0);
   endtask

   task automatic t_ready_gate();
      int b;
      b = nlog;
      push(32'hA1B2C3D4);
      idle(10);
      chk(nlog == b, "R2 no start while guest not ready", nlog - b, 0);
      guest_ready = 1;
      idle(30);
      chk(nlog == b + 4, "R2 starts once ready", nlog - b, 4);
      chk_stream(b, 32'hA1B2C3D4, "R3 byte order");
      chk(pops == 1, "R4 one pop per word", pops, 1);
   endtask

   task automatic t_mbox_wr();
      int b;
      b = nlog;
      mbox_write(1, 1, 5, 2, 8'h5A);
      idle(10);
      chk(nlog == b + 1 && lg_wr[b] && lg_guest[b] == 5 && lg_reg[b] == 2 && lg_data[b] == 8'h5A,
          "R6 mailbox write request", lg_data[b], 8'h5A);
      chk(!mbox_pend, "R8 pending cleared", mbox_pend, 0);
   endtask

   task automatic t_mbox_rd();
      int b;
      b = nlog;
      tb_rd = 8'h3C;
      mbox_write(1, 0, 2, 1, 8'h00);
      idle(10);
      chk(nlog == b + 1 && !lg_wr[b] && lg_guest[b] == 2 && lg_reg[b] == 1, "R7 read request", lg_wr[b], 0);
      chk(mbox_data == 8'h3C, "R7 read data stored", mbox_data, 8'h3C);
      chk(!mbox_pend, "R8 pending cleared after read", mbox_pend, 0);
   endtask

   task automatic t_preempt();
      int b;
      b = nlog;
      push(32'h11223344);
      while (nlog == b) @(negedge clk);
      mbox_write(1, 1, 3, 7, 8'hE7);
      idle(40);
      chk(nlog == b + 5, "R5 five cycles", nlog - b, 5);
      chk(lg_data[b] == 8'h44 && lg_guest[b] == strm_guest, "R5 stream byte first", lg_data[b], 8'h44);
      chk(lg_guest[b+1] == 3 && lg_reg[b+1] == 7 && lg_data[b+1] == 8'hE7, "R5 mailbox second", lg_data[b+1], 8'hE7);
      chk(lg_data[b+2] == 8'h33 && lg_data[b+3] == 8'h22 && lg_data[b+4] == 8'h11, "R5 stream resumes",
          lg_data[b+4], 8'h11);
      chk(pops == 2, "R4 pop after fourth byte", pops, 2);
   endtask

   task automatic t_mbox_to();
      tb_to = 1; tb_rd = 8'hFF;
      mbox_write(1, 0, 4, 4, 8'h9D);
      idle(10);
      chk(mbox_timeout, "R9 mailbox time-out set", mbox_timeout, 1);
      chk(!mbox_pend, "R9 pending cleared", mbox_pend, 0);
      chk(mbox_data == 8'h9D, "R9 data unchanged", mbox_data, 8'h9D);
      chk(!strm_timeout, "R10 stream flag untouched", strm_timeout, 0);
      tb_to = 0;
      idle(3);
      chk(mbox_timeout, "R11 sticky", mbox_timeout, 1);
      @(negedge clk); host_clr_mto = 1; @(negedge clk); host_clr_mto = 0;
      chk(!mbox_timeout, "R11 cleared", mbox_timeout, 0);
   endtask

   task automatic t_strm_to();
      tb_to = 1;
      push(32'hCAFE0001);
      idle(30);
      chk(strm_timeout, "R10 stream time-out set", strm_timeout, 1);
      chk(!mbox_timeout, "R10 mailbox flag untouched", mbox_timeout, 0);
      chk(pops == 3, "R4 timed-out bytes consumed", pops, 3);
      tb_to = 0;
      @(negedge clk); host_clr_sto = 1; @(negedge clk); host_clr_sto = 0;
      chk(!strm_timeout, "R11 stream flag cleared", strm_timeout, 0);
   endtask

   task automatic t_set_vs_clear();
      tb_to = 1;
      mbox_write(1, 0, 1, 1, 8'h00);
      while (!cyc_done) @(negedge clk);
      host_clr_mto = 1;
      @(negedge clk);
      host_clr_mto = 0;
      chk(mbox_timeout, "R11 set wins over clear", mbox_timeout, 1);
      tb_to = 0;
      @(negedge clk); host_clr_mto = 1; @(negedge clk); host_clr_mto = 0;
   endtask

   task automatic t_ignore();
      int b;
      b = nlog;
      mbox_write(1, 1, 1, 6, 8'h11);
      mbox_write(1, 0, 7, 3, 8'h77);
      idle(15);
      chk(nlog == b + 1 && lg_guest[b] == 1 && lg_wr[b] && lg_data[b] == 8'h11, "R12 only first write runs",
          lg_guest[b], 1);
      chk(mbox_data == 8'h11 && mbox_guest == 1 && mbox_reg == 6 && mbox_dir, "R12 fields kept", mbox_data, 8'h11);
      chk(!mbox_pend, "R12 pending clear afterwards", mbox_pend, 0);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(4);
      t_reset();
      @(negedge clk) rst_n = 1;
      idle(2);
      t_reset();
      t_ready_gate();
      t_mbox_wr();
      t_mbox_rd();
      t_preempt();
      t_mbox_to();
      t_strm_to();
      t_set_vs_clear();
      t_ignore();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule